// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between an 8-bit CPU with a 16-bit address bus and a wider 20-bit system bus. It divides the CPU address space into sixteen 4 KB pages. The top four CPU address bits pick one of sixteen 8-bit mapping registers, and that register supplies the upper eight bits of the bus address. The low twelve bits go through unchanged. Sixteen pages of the CPU view can therefore reach any of 256 physical 4 KB frames, which covers 1 MB.

One clock drives the unit. A phase input marks the two halves of the bus cycle. On a clock edge in the low phase the block computes the translated address and registers it. On a clock edge in the high phase it serves a register access: a chip select, a read/write flag and a four-bit index pick one mapping register. Out of reset the unit runs in pass-through mode, so the CPU page number appears on bus bits 15..12 and bits 19..16 are zero. The first register write switches the unit to mapped mode, and only a reset returns it to pass-through.

Top module: `paged_map`

## Requirements
- R1: While reset is asserted, all sixteen mapping registers, `busAddr` and `ioRdData` clear to zero, and the unit enters pass-through mode.
- R2: In pass-through mode, a clock edge with `phiHigh`=0 loads `busAddr` with {4'b0000, cpuAddr[15:0]}.
- R3: On every clock edge with `phiHigh`=0, `busAddr[11:0]` takes `cpuAddr[11:0]`, whatever the mode.
- R4: In mapped mode, a clock edge with `phiHigh`=0 loads `busAddr[19:12]` from the mapping register indexed by `cpuAddr[15:12]`.
- R5: A clock edge with `phiHigh`=1, `ioSel`=1 and `ioWr`=1 stores `ioWrData` in the register selected by `ioIdx`. With `ioSel`=0 nothing is stored.
- R6: A clock edge with `phiHigh`=1, `ioSel`=1 and `ioWr`=0 loads `ioRdData` with the register selected by `ioIdx`. On every other edge `ioRdData` keeps its value.
- R7: The first stored write switches the unit to mapped mode. It stays mapped, even after later writes of zero, until the next reset.
- R8: A read in pass-through mode returns the stored register contents (zero after reset), not the page index.
- R9: `busAddr` keeps its value across every clock edge with `phiHigh`=1.
- R10: A register access that arrives with `phiHigh`=0 is ignored. It stores nothing and does not enable mapped mode.
- R11: A read access does not enable mapped mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phiHigh | input | 1 | Bus phase: 0 = translate, 1 = register access |
| cpuAddr | input | 16 | CPU address |
| ioSel | input | 1 | Chip select for register access |
| ioWr | input | 1 | 1 = write, 0 = read |
| ioIdx | input | 4 | Mapping register index |
| ioWrData | input | 8 | Write data |
| busAddr | output | 20 | Registered translated bus address |
| ioRdData | output | 8 | Registered read data |

## Verification
The bench first uses addresses whose pass-through and mapped results differ, such as page 0 mapped to frame 0xA0. A unit that enabled mapping late, or that dropped back to pass-through after a zero write, gives a different upper nibble at those addresses. It reads a register before any write so that a design returning the page index instead of the stored value is caught. It also sends access strobes in the wrong phase and without chip select. A decoder that ignores either qualifier would change stored data or leave pass-through early. Finally it changes the CPU address during register-access cycles, which catches a translation latch that also opens in the high phase.

// File: rtl/paged_map_pkg.sv
package paged_map_pkg;
  // strobes sent from the phase control to the datapath
  typedef struct packed {
    logic latchEn;  // capture translated address
    logic wrEn;     // store into mapping register
    logic rdEn;     // capture read data
  } mapCtl_t;
endpackage

// File: rtl/paged_map_ctrl.sv
module paged_map_ctrl
  import paged_map_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    phiHigh,
  input  logic    ioSel,
  input  logic    ioWr,
  output mapCtl_t ctl,
  output logic    mapEn
);
  always_comb begin
    ctl.latchEn = !phiHigh;
    ctl.wrEn    = phiHigh && ioSel && ioWr;
    ctl.rdEn    = phiHigh && ioSel && !ioWr;
  end

  // sticky enable: set by the first stored write, cleared only by reset
  always_ff @(posedge clk) begin
    if (!rstN)          mapEn <= 1'b0;
    else if (ctl.wrEn)  mapEn <= 1'b1;
  end

  // R7
  mapStick_chk: assert property (@(posedge clk) disable iff (!rstN)
    mapEn |=> mapEn);

  // R11
  readNoEnable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phiHigh && ioSel && !ioWr && !mapEn) |=> !mapEn);

  // R10
  lowPhaseNoEnable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!phiHigh && !mapEn) |=> !mapEn);
endmodule

// File: rtl/paged_map_dp.sv
module paged_map_dp
  import paged_map_pkg::*;
#(
  parameter int CPU_AW    = 16,
  parameter int PAGE_BITS = 4,
  parameter int FRAME_W   = 8,
  localparam int OFF_W    = CPU_AW - PAGE_BITS,
  localparam int BUS_AW   = OFF_W + FRAME_W,
  localparam int NREG     = 1 << PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mapCtl_t              ctl,
  input  logic                 mapEn,
  input  logic [CPU_AW-1:0]    cpuAddr,
  input  logic [PAGE_BITS-1:0] ioIdx,
  input  logic [FRAME_W-1:0]   ioWrData,
  output logic [BUS_AW-1:0]    busAddr,
  output logic [FRAME_W-1:0]   ioRdData
);
  logic [FRAME_W-1:0]   regFile [NREG];
  logic [PAGE_BITS-1:0] page;
  logic [FRAME_W-1:0]   passFrame;
  logic [FRAME_W-1:0]   frameSel;
  logic [FRAME_W-1:0]   rdMux;

  // one flop group per mapping register
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regFile[i] <= '0;
      else if (ctl.wrEn && (ioIdx == PAGE_BITS'(i)))
        regFile[i] <= ioWrData;
    end
  end

  assign page      = cpuAddr[CPU_AW-1:OFF_W];
  assign passFrame = {{(FRAME_W-PAGE_BITS){1'b0}}, page};
  assign frameSel  = mapEn ? regFile[page] : passFrame;
  assign rdMux     = regFile[ioIdx];

  always_ff @(posedge clk) begin
    if (!rstN)            busAddr <= '0;
    else if (ctl.latchEn) busAddr <= {frameSel, cpuAddr[OFF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)         ioRdData <= '0;
    else if (ctl.rdEn) ioRdData <= rdMux;
  end

  // R6
  readData_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdEn |=> (ioRdData == $past(rdMux)));

  // R6
  readHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdEn |=> $stable(ioRdData));
endmodule

// File: rtl/paged_map.sv
module paged_map
  import paged_map_pkg::*;
#(
  parameter int CPU_AW    = 16,
  parameter int PAGE_BITS = 4,
  parameter int FRAME_W   = 8,
  localparam int OFF_W    = CPU_AW - PAGE_BITS,
  localparam int BUS_AW   = OFF_W + FRAME_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 phiHigh,
  input  logic [CPU_AW-1:0]    cpuAddr,
  input  logic                 ioSel,
  input  logic                 ioWr,
  input  logic [PAGE_BITS-1:0] ioIdx,
  input  logic [FRAME_W-1:0]   ioWrData,
  output logic [BUS_AW-1:0]    busAddr,
  output logic [FRAME_W-1:0]   ioRdData
);
  mapCtl_t ctl;
  logic    mapEn;

  paged_map_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .phiHigh(phiHigh),
    .ioSel(ioSel), .ioWr(ioWr), .ctl(ctl), .mapEn(mapEn)
  );

  paged_map_dp #(.CPU_AW(CPU_AW), .PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mapEn(mapEn), .cpuAddr(cpuAddr),
    .ioIdx(ioIdx), .ioWrData(ioWrData), .busAddr(busAddr), .ioRdData(ioRdData)
  );

  // R9
  busHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    phiHigh |=> $stable(busAddr));

  // R3
  offsetPass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !phiHigh |=> (busAddr[OFF_W-1:0] == $past(cpuAddr[OFF_W-1:0])));

  // R2
  passUpper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!phiHigh && !mapEn) |=> (busAddr[BUS_AW-1:CPU_AW] == '0));
endmodule

// File: tb/sim_paged_map.sv
module sim_paged_map;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phiHigh = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        ioSel = 1'b0;
  logic        ioWr = 1'b0;
  logic [3:0]  ioIdx = '0;
  logic [7:0]  ioWrData = '0;
  logic [19:0] busAddr;
  logic [7:0]  ioRdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  paged_map u0 (
    .clk(clk), .rstN(rstN), .phiHigh(phiHigh), .cpuAddr(cpuAddr),
    .ioSel(ioSel), .ioWr(ioWr), .ioIdx(ioIdx), .ioWrData(ioWrData),
    .busAddr(busAddr), .ioRdData(ioRdData)
  );

  // mapped-mode vectors with register i programmed to 8'hA0+i: {cpuAddr, expected busAddr}
  localparam int NVEC = 8;
  localparam logic [35:0] VEC [NVEC] = '{
    {16'h0123, 20'hA0123}, {16'hF456, 20'hAF456},
    {16'h7FFF, 20'hA7FFF}, {16'h8000, 20'hA8000},
    {16'h1000, 20'hA1000}, {16'hEFFF, 20'hAEFFF},
    {16'h3ABC, 20'hA3ABC}, {16'hC001, 20'hAC001}
  };

  task automatic chk(input logic [19:0] act, input logic [19:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lowPhase(input logic [15:0] a);
    @(negedge clk);
    phiHigh = 1'b0; ioSel = 1'b0; cpuAddr = a;
    @(negedge clk);
  endtask

  task automatic ioWrite(input logic [3:0] idx, input logic [7:0] d, input logic sel);
    @(negedge clk);
    phiHigh = 1'b1; ioSel = sel; ioWr = 1'b1; ioIdx = idx; ioWrData = d;
    @(negedge clk);
    ioSel = 1'b0; ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [3:0] idx);
    @(negedge clk);
    phiHigh = 1'b1; ioSel = 1'b1; ioWr = 1'b0; ioIdx = idx;
    @(negedge clk);
    ioSel = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busAddr, 20'h0, "R1 busAddr in reset");
    chk({12'h0, ioRdData}, 20'h0, "R1 ioRdData in reset");
    rstN = 1'b1;

    // pass-through
    lowPhase(16'hF123); chk(busAddr, 20'h0F123, "R2 pass F123");
    lowPhase(16'hABCD); chk(busAddr, 20'h0ABCD, "R2 R3 pass ABCD");
    ioRead(4'd2); chk({12'h0, ioRdData}, 20'h0, "R8 read in pass mode");
    lowPhase(16'h2345); chk(busAddr, 20'h02345, "R11 read keeps pass mode");

    // access strobes in the low phase are ignored
    @(negedge clk);
    phiHigh = 1'b0; ioSel = 1'b1; ioWr = 1'b1; ioIdx = 4'd4; ioWrData = 8'h55; cpuAddr = 16'h4000;
    @(negedge clk);
    ioSel = 1'b0; ioWr = 1'b0;
    chk(busAddr, 20'h04000, "R10 low-phase write latch");
    lowPhase(16'h4111); chk(busAddr, 20'h04111, "R10 still pass mode");
    ioRead(4'd4); chk({12'h0, ioRdData}, 20'h0, "R10 low-phase write not stored");

    // write without chip select
    ioWrite(4'd6, 8'h77, 1'b0);
    lowPhase(16'h6000); chk(busAddr, 20'h06000, "R5 unselected write no enable");
    ioRead(4'd6); chk({12'h0, ioRdData}, 20'h0, "R5 unselected write not stored");

    // first write enables mapping
    ioWrite(4'd0, 8'hA0, 1'b1);
    lowPhase(16'h0234); chk(busAddr, 20'hA0234, "R7 R4 first write maps");
    lowPhase(16'h5234); chk(busAddr, 20'h00234, "R7 unwritten reg mapped as zero");

    // program all and walk the table
    for (int i = 0; i < 16; i++) ioWrite(4'(i), 8'hA0 + 8'(i), 1'b1);
    for (int v = 0; v < NVEC; v++) begin
      lowPhase(VEC[v][35:20]);
      chk(busAddr, VEC[v][19:0], "R4 R3 mapped vector");
    end
    for (int i = 0; i < 16; i++) begin
      ioRead(4'(i));
      chk({12'h0, ioRdData}, {12'h0, 8'hA0 + 8'(i)}, "R5 R6 readback");
    end

    // high phase must not move busAddr
    lowPhase(16'h9876); chk(busAddr, 20'hA9876, "R4 before hold");
    @(negedge clk);
    phiHigh = 1'b1; ioSel = 1'b1; ioWr = 1'b0; ioIdx = 4'd1; cpuAddr = 16'h1111;
    @(negedge clk);
    ioSel = 1'b0; cpuAddr = 16'h2222;
    @(negedge clk);
    chk(busAddr, 20'hA9876, "R9 hold in high phase");
    chk({12'h0, ioRdData}, 20'h000A1, "R6 read reg1");
    @(negedge clk);
    chk({12'h0, ioRdData}, 20'h000A1, "R6 read data held");

    // zero writes do not leave mapped mode
    for (int i = 0; i < 16; i++) ioWrite(4'(i), 8'h00, 1'b1);
    lowPhase(16'h3ABC); chk(busAddr, 20'h00ABC, "R7 stays mapped after zero writes");
    ioWrite(4'd3, 8'hFF, 1'b1);
    lowPhase(16'h3ABC); chk(busAddr, 20'hFFABC, "R4 full frame");

    // reset again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk(busAddr, 20'h0, "R1 busAddr after second reset");
    rstN = 1'b1;
    lowPhase(16'h3ABC); chk(busAddr, 20'h03ABC, "R1 R2 back to pass mode");
    ioRead(4'd3); chk({12'h0, ioRdData}, 20'h0, "R1 registers cleared");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule